// File: doc/BRIEF.md
# Lane Override Sequencer

This controller forces the receive clock-recovery mode and the transmit attenuation of one serial link lane. It does this by issuing a fixed series of reads and writes to a separate indirect PHY register access engine. A command carries a port number. The block turns that number into a PHY index and a lane index, then walks through its access list one transfer at a time. The register access engine itself sits outside the block.

An apply command does three things in order. It first waits until the lane has left half-rate operation. It then moves the receive override through three writes: enable cleared, enable set, and finally the mode field inserted. Last, unless a per-lane strap bit says otherwise, it does the same for the transmit override with the attenuation value. A disable command clears both override enables with read-modify-write cycles. The strap word is a static input that holds one 4-bit attenuation nibble per lane.

Top module: `lane_ovr_seq`

## Requirements
- R1: Port 0 selects PHY 5 lane 0. Ports 1 to 4 select PHY 0 lanes 0 to 3. Every lane register address is its base plus lane×0x100. The bases are TX status 0x2001, RX status 0x2002, TX override 0x2004 and RX override 0x2005.
- R2: A command whose port is 5 or higher is dropped. No transfer is issued, busy stays low and no done pulse appears.
- R3: An apply command first reads RX status of PHY 0 at the selected lane's address, whatever PHY the port maps to. The read repeats while bit 0 (half-rate) is 1, up to POLL_MAX reads in total.
- R4: poll_timeout is 1 at done if all POLL_MAX polls returned bit 0 set. In that case the sequence still continues. The flag is cleared when a command is accepted.
- R5: The receive step reads RX status from the mapped PHY into a value V. It then writes RX override three times: V with bit 14 cleared; V with bit 14 set; V with bit 14 set and bits 10:8 replaced by 3.
- R6: The attenuation nibble is strap[4s+3:4s], with s = 4 for port 0 and s = lane otherwise. If nibble bit 3 is 1, the transmit step is skipped.
- R7: The transmit step reads TX status into a value T. It then writes TX override three times: T with bit 15 cleared; T with bit 15 set; T with bit 15 set ORed with (nibble<<10)&0x1C00.
- R8: A disable command (cmd_disable=1) does four transfers. It reads RX status, then writes that value to RX override with bit 14 cleared. It reads TX override, then writes it back with bit 15 cleared.
- R9: Each transfer is a read (acc_write=0) or a write (acc_write=1). It completes in a cycle where acc_req and acc_ack are both 1, and read data is taken in that cycle. While waiting for ack, the request and all its fields stay stable.
- R10: done is a one-cycle pulse in the cycle after the last transfer. busy is 1 from the cycle after acceptance through the done cycle.
- R11: A command presented while busy is ignored.
- R12: After reset, busy, done, acc_req and poll_timeout are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_disable | input | 1 | 1 = clear overrides, 0 = apply overrides |
| cmd_port | input | PORT_W | Port number |
| strap | input | STRAP_W | Per-lane attenuation nibbles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| poll_timeout | output | 1 | Half-rate wait hit its limit |
| acc_req | output | 1 | Transfer request to the access engine |
| acc_write | output | 1 | 1 = write, 0 = read |
| acc_phy | output | PHY_W | Target PHY index |
| acc_addr | output | ADDR_W | Target register address |
| acc_wdata | output | DATA_W | Write data |
| acc_ack | input | 1 | Transfer accepted this cycle |
| acc_rdata | input | DATA_W | Read data, valid with acc_ack |

## Verification
Apply commands are run on every valid port with different half-rate wait lengths: zero, a few, one less than the limit, and exactly the limit. The last two tell an early exit apart from a timeout. Strap nibbles with bit 3 set and clear separate the skipped transmit step from the applied one. RX and TX values with bit 14, bit 15 and bits 10:8 already set show that the mode field is replaced while the attenuation field is ORed. Disable commands, out-of-range ports, and commands sent mid-sequence are run under both a constant and an irregular acknowledge pattern, which checks that the fields hold steady while the block waits.

// File: rtl/lane_ovr_pkg.sv
package lane_ovr_pkg;
  localparam int REG_AW = 16;
  localparam logic [REG_AW-1:0] TX_STS_BASE = 16'h2001;
  localparam logic [REG_AW-1:0] RX_STS_BASE = 16'h2002;
  localparam logic [REG_AW-1:0] TX_OVR_BASE = 16'h2004;
  localparam logic [REG_AW-1:0] RX_OVR_BASE = 16'h2005;
  localparam int LANE_SHIFT  = 8;
  localparam int HALF_BIT    = 0;
  localparam int RX_EN_BIT   = 14;
  localparam int TX_EN_BIT   = 15;
  localparam int MODE_LSB    = 8;
  localparam int MODE_W      = 3;
  localparam int ATTEN_LSB   = 10;
  localparam int ATTEN_W     = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL,
    ST_RX_RD, ST_RX_W0, ST_RX_W1, ST_RX_W2,
    ST_TX_RD, ST_TX_W0, ST_TX_W1, ST_TX_W2,
    ST_DX_RD, ST_DX_WR, ST_DT_RD, ST_DT_WR,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/lane_ovr_map.sv
module lane_ovr_map #(
  parameter int PORT_W    = 3,
  parameter int PHY_W     = 3,
  parameter int LANE_W    = 2,
  parameter int STRAP_W   = 32,
  parameter int NUM_PORTS = 5,
  parameter int ALT_PHY   = 5,
  parameter int ALT_SLOT  = 4
) (
  input  logic [PORT_W-1:0]  port,
  input  logic [STRAP_W-1:0] strap,
  output logic               ok,
  output logic [PHY_W-1:0]   phy,
  output logic [LANE_W-1:0]  lane,
  output logic [3:0]         nibble
);
  localparam int SLOTS = STRAP_W / 4;
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0] slot;

  always_comb begin
    ok = (int'(port) < NUM_PORTS);
    if (port == '0) begin
      phy  = PHY_W'(ALT_PHY);
      lane = '0;
      slot = SLOT_W'(ALT_SLOT);
    end else begin
      phy  = '0;
      lane = LANE_W'(port - PORT_W'(1));
      slot = SLOT_W'(port - PORT_W'(1));
    end
    nibble = strap[slot*4 +: 4];
  end
endmodule

// File: rtl/lane_ovr_poll.sv
module lane_ovr_poll #(
  parameter int POLL_MAX = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(POLL_MAX + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (inc && cnt_q != CW'(POLL_MAX)) cnt_q <= cnt_q + CW'(1);
  end

  assign last = (cnt_q == CW'(POLL_MAX - 1));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(POLL_MAX));
endmodule

// File: rtl/lane_ovr_decode.sv
module lane_ovr_decode
  import lane_ovr_pkg::*;
#(
  parameter int PHY_W     = 3,
  parameter int LANE_W    = 2,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int POLL_PHY  = 0,
  parameter int DPLL_MODE = 3
) (
  input  seq_state_t        st,
  input  logic [PHY_W-1:0]  phy,
  input  logic [LANE_W-1:0] lane,
  input  logic [3:0]        nibble,
  input  logic [DATA_W-1:0] val,
  output logic              req,
  output logic              wr,
  output logic [PHY_W-1:0]  tphy,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  localparam logic [DATA_W-1:0] RX_EN  = DATA_W'(1) << RX_EN_BIT;
  localparam logic [DATA_W-1:0] TX_EN  = DATA_W'(1) << TX_EN_BIT;
  localparam logic [DATA_W-1:0] MODE_M = DATA_W'((1 << MODE_W) - 1) << MODE_LSB;
  localparam logic [DATA_W-1:0] ATT_M  = DATA_W'((1 << ATTEN_W) - 1) << ATTEN_LSB;

  logic [ADDR_W-1:0] off;
  assign off = ADDR_W'(lane) << LANE_SHIFT;

  always_comb begin
    req   = 1'b1;
    wr    = 1'b0;
    tphy  = phy;
    addr  = '0;
    wdata = '0;
    case (st)
      ST_POLL:  begin tphy = PHY_W'(POLL_PHY); addr = ADDR_W'(RX_STS_BASE) + off; end
      ST_RX_RD,
      ST_DX_RD: addr = ADDR_W'(RX_STS_BASE) + off;
      ST_RX_W0,
      ST_DX_WR: begin wr = 1'b1; addr = ADDR_W'(RX_OVR_BASE) + off; wdata = val & ~RX_EN; end
      ST_RX_W1: begin wr = 1'b1; addr = ADDR_W'(RX_OVR_BASE) + off; wdata = val | RX_EN; end
      ST_RX_W2: begin
        wr = 1'b1; addr = ADDR_W'(RX_OVR_BASE) + off;
        wdata = ((val | RX_EN) & ~MODE_M) | ((DATA_W'(DPLL_MODE) << MODE_LSB) & MODE_M);
      end
      ST_TX_RD: addr = ADDR_W'(TX_STS_BASE) + off;
      ST_DT_RD: addr = ADDR_W'(TX_OVR_BASE) + off;
      ST_TX_W0,
      ST_DT_WR: begin wr = 1'b1; addr = ADDR_W'(TX_OVR_BASE) + off; wdata = val & ~TX_EN; end
      ST_TX_W1: begin wr = 1'b1; addr = ADDR_W'(TX_OVR_BASE) + off; wdata = val | TX_EN; end
      ST_TX_W2: begin
        wr = 1'b1; addr = ADDR_W'(TX_OVR_BASE) + off;
        wdata = val | TX_EN | ((DATA_W'(nibble) << ATTEN_LSB) & ATT_M);
      end
      default:  req = 1'b0;
    endcase
  end
endmodule

// File: rtl/lane_ovr_seq.sv
module lane_ovr_seq
  import lane_ovr_pkg::*;
#(
  parameter int PORT_W    = 3,
  parameter int PHY_W     = 3,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int STRAP_W   = 32,
  parameter int NUM_PORTS = 5,
  parameter int POLL_MAX  = 1000,
  parameter int DPLL_MODE = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic               cmd_disable,
  input  logic [PORT_W-1:0]  cmd_port,
  input  logic [STRAP_W-1:0] strap,
  output logic               busy,
  output logic               done,
  output logic               poll_timeout,
  output logic               acc_req,
  output logic               acc_write,
  output logic [PHY_W-1:0]   acc_phy,
  output logic [ADDR_W-1:0]  acc_addr,
  output logic [DATA_W-1:0]  acc_wdata,
  input  logic               acc_ack,
  input  logic [DATA_W-1:0]  acc_rdata
);
  localparam int LANE_W = $clog2(NUM_PORTS - 1);

  seq_state_t        st_q, st_d;
  logic [PHY_W-1:0]  phy_q, phy_d, map_phy;
  logic [LANE_W-1:0] lane_q, lane_d, map_lane;
  logic [3:0]        nib_q, nib_d, map_nib;
  logic [DATA_W-1:0] val_q, val_d;
  logic              to_q, to_d, map_ok, accept, xfer, poll_last;

  lane_ovr_map #(
    .PORT_W(PORT_W), .PHY_W(PHY_W), .LANE_W(LANE_W), .STRAP_W(STRAP_W),
    .NUM_PORTS(NUM_PORTS), .ALT_PHY(5), .ALT_SLOT(4)
  ) u_map (
    .port(cmd_port), .strap(strap), .ok(map_ok),
    .phy(map_phy), .lane(map_lane), .nibble(map_nib)
  );

  assign accept = cmd_valid && (st_q == ST_IDLE) && map_ok;
  assign xfer   = acc_req && acc_ack;

  lane_ovr_poll #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst(rst), .clear(accept),
    .inc(xfer && st_q == ST_POLL), .last(poll_last)
  );

  always_comb begin
    st_d   = st_q;
    phy_d  = phy_q;
    lane_d = lane_q;
    nib_d  = nib_q;
    val_d  = val_q;
    to_d   = to_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = cmd_disable ? ST_DX_RD : ST_POLL;
        phy_d  = map_phy;
        lane_d = map_lane;
        nib_d  = map_nib;
        to_d   = 1'b0;
      end
      ST_POLL: if (xfer && (!acc_rdata[HALF_BIT] || poll_last)) begin
        st_d = ST_RX_RD;
        to_d = acc_rdata[HALF_BIT];
      end
      ST_RX_RD: if (xfer) begin val_d = acc_rdata; st_d = ST_RX_W0; end
      ST_RX_W0: if (xfer) st_d = ST_RX_W1;
      ST_RX_W1: if (xfer) st_d = ST_RX_W2;
      ST_RX_W2: if (xfer) st_d = nib_q[3] ? ST_FIN : ST_TX_RD;
      ST_TX_RD: if (xfer) begin val_d = acc_rdata; st_d = ST_TX_W0; end
      ST_TX_W0: if (xfer) st_d = ST_TX_W1;
      ST_TX_W1: if (xfer) st_d = ST_TX_W2;
      ST_TX_W2: if (xfer) st_d = ST_FIN;
      ST_DX_RD: if (xfer) begin val_d = acc_rdata; st_d = ST_DX_WR; end
      ST_DX_WR: if (xfer) st_d = ST_DT_RD;
      ST_DT_RD: if (xfer) begin val_d = acc_rdata; st_d = ST_DT_WR; end
      ST_DT_WR: if (xfer) st_d = ST_FIN;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      phy_q  <= '0;
      lane_q <= '0;
      nib_q  <= '0;
      val_q  <= '0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      phy_q  <= phy_d;
      lane_q <= lane_d;
      nib_q  <= nib_d;
      val_q  <= val_d;
      to_q   <= to_d;
    end
  end

  lane_ovr_decode #(
    .PHY_W(PHY_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .POLL_PHY(0), .DPLL_MODE(DPLL_MODE)
  ) u_dec (
    .st(st_q), .phy(phy_q), .lane(lane_q), .nibble(nib_q), .val(val_q),
    .req(acc_req), .wr(acc_write), .tphy(acc_phy), .addr(acc_addr), .wdata(acc_wdata)
  );

  assign busy         = (st_q != ST_IDLE);
  assign done         = (st_q == ST_FIN);
  assign poll_timeout = to_q;

  p_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && int'(cmd_port) >= NUM_PORTS) |=> !busy);
  p_req_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_ack) |=> (acc_req && $stable(acc_write) && $stable(acc_phy)
                               && $stable(acc_addr) && $stable(acc_wdata)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_xfer_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(acc_req && acc_ack));
  p_idle_no_req_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !acc_req);
endmodule

// File: tb/tb_lane_ovr_seq.sv
`timescale 1ns/1ps
module tb_lane_ovr_seq;
  localparam int POLL_MAX = 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_disable = 1'b0;
  logic [2:0]  cmd_port = '0;
  logic [31:0] strap = 32'h0005_7C93;
  logic        busy, done, poll_timeout, acc_req, acc_write;
  logic [2:0]  acc_phy;
  logic [15:0] acc_addr;
  logic [31:0] acc_wdata;
  logic        acc_ack = 1'b0;
  logic [31:0] acc_rdata = '0;

  always #2.5 clk = ~clk;

  lane_ovr_seq #(.POLL_MAX(POLL_MAX)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_disable(cmd_disable),
    .cmd_port(cmd_port), .strap(strap), .busy(busy), .done(done),
    .poll_timeout(poll_timeout), .acc_req(acc_req), .acc_write(acc_write),
    .acc_phy(acc_phy), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ack(acc_ack), .acc_rdata(acc_rdata)
  );

  typedef struct {
    bit    wr;
    int    phy;
    int    addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    string tag;
  } xfer_t;

  xfer_t exq[$];
  int    checks = 0;
  int    fails = 0;
  bit    active = 0;
  bit    exp_to = 0;
  bit    pop_pend = 0;
  bit    done_due = 0;
  bit    ack_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic xfer_t mk(bit wr, int phy, int addr, logic [31:0] wd,
                               logic [31:0] rd, string tag);
    xfer_t x;
    x.wr = wr; x.phy = phy; x.addr = addr; x.wdata = wd; x.rdata = rd; x.tag = tag;
    return x;
  endfunction

  // expected access list for one command, built from the requirements
  task automatic plan_cmd(input int port, input bit dis, input int nhalf,
                          input logic [31:0] v, input logic [31:0] t);
    int phy, lane, slot, nreads;
    logic [3:0] nib;
    logic [31:0] w;
    phy  = (port == 0) ? 5 : 0;                 // R1
    lane = (port == 0) ? 0 : port - 1;
    slot = (port == 0) ? 4 : lane;              // R6
    nib  = strap[slot*4 +: 4];
    if (dis) begin                              // R8
      exq.push_back(mk(0, phy, 'h2002 + lane*256, 0, v, "R8"));
      exq.push_back(mk(1, phy, 'h2005 + lane*256, v & ~32'h4000, 0, "R8"));
      exq.push_back(mk(0, phy, 'h2004 + lane*256, 0, t, "R8"));
      exq.push_back(mk(1, phy, 'h2004 + lane*256, t & ~32'h8000, 0, "R8"));
      exp_to = 0;
    end else begin
      nreads = (nhalf + 1 < POLL_MAX) ? nhalf + 1 : POLL_MAX;   // R3
      for (int i = 0; i < nreads; i++)
        exq.push_back(mk(0, 0, 'h2002 + lane*256, 0,
                         (i < nhalf) ? 32'h5A00_0001 : 32'h5A00_0000, "R3"));
      exp_to = (nhalf >= POLL_MAX);                             // R4
      exq.push_back(mk(0, phy, 'h2002 + lane*256, 0, v, "R1_R5"));
      w = v & ~32'h4000;
      exq.push_back(mk(1, phy, 'h2005 + lane*256, w, 0, "R5"));
      w = v | 32'h4000;
      exq.push_back(mk(1, phy, 'h2005 + lane*256, w, 0, "R5"));
      w = (w & ~32'h0700) | 32'h0300;
      exq.push_back(mk(1, phy, 'h2005 + lane*256, w, 0, "R5"));
      if (!nib[3]) begin                        // R6 / R7
        exq.push_back(mk(0, phy, 'h2001 + lane*256, 0, t, "R7"));
        exq.push_back(mk(1, phy, 'h2004 + lane*256, t & ~32'h8000, 0, "R7"));
        w = t | 32'h8000;
        exq.push_back(mk(1, phy, 'h2004 + lane*256, w, 0, "R7"));
        w = w | ((32'(nib) << 10) & 32'h1C00);
        exq.push_back(mk(1, phy, 'h2004 + lane*256, w, 0, "R6_R7"));
      end
    end
  endtask

  task automatic issue(input int port, input bit dis, input bit expect_run,
                       input int nhalf, input logic [31:0] v, input logic [31:0] t);
    @(negedge clk);
    cmd_valid = 1; cmd_disable = dis; cmd_port = 3'(port);
    #2;
    if (expect_run) begin
      plan_cmd(port, dis, nhalf, v, t);
      active = 1;
    end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // access engine model and per-clock comparison
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pop_pend) begin
          void'(exq.pop_front());
          pop_pend = 0;
          if (exq.size() == 0 && active) done_due = 1;
        end
        chk(done == done_due, "R10", "done", 32'(done), 32'(done_due));
        if (done_due)
          chk(poll_timeout == exp_to, "R4", "poll_timeout", 32'(poll_timeout), 32'(exp_to));
        chk(busy == active, "R10_R11", "busy", 32'(busy), 32'(active));
        if (exq.size() == 0)
          chk(acc_req == 1'b0, "R2_R11", "spurious acc_req", 32'(acc_req), 0);
        if (done_due) begin active = 0; done_due = 0; end
      end
      acc_rdata = (exq.size() != 0) ? exq[0].rdata : 32'h0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      acc_ack = ack_rand ? lfsr[0] : 1'b1;
      #1;
      if (!rst && acc_req && acc_ack && exq.size() != 0) begin
        chk(acc_write == exq[0].wr, exq[0].tag, "acc_write", 32'(acc_write), 32'(exq[0].wr));
        chk(int'(acc_phy) == exq[0].phy, exq[0].tag, "acc_phy", 32'(acc_phy), 32'(exq[0].phy));
        chk(int'(acc_addr) == exq[0].addr, exq[0].tag, "acc_addr", 32'(acc_addr), 32'(exq[0].addr));
        if (exq[0].wr)
          chk(acc_wdata == exq[0].wdata, exq[0].tag, "acc_wdata", acc_wdata, exq[0].wdata);
        pop_pend = 1;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1.5;
    // R12: reset state
    chk(busy == 0, "R12", "busy after reset", 32'(busy), 0);
    chk(done == 0, "R12", "done after reset", 32'(done), 0);
    chk(acc_req == 0, "R12", "acc_req after reset", 32'(acc_req), 0);
    chk(poll_timeout == 0, "R12", "poll_timeout after reset", 32'(poll_timeout), 0);

    // R1 R5 R7: port 0, no wait, attenuation applied
    issue(0, 0, 1, 0, 32'h0000_4500, 32'h0000_1C00);
    wait_idle();
    ack_rand = 1;
    // R6: lane 2 nibble has bit 3 set, transmit step skipped; R3 short wait
    issue(3, 0, 1, 3, 32'h1234_0700, 32'hFFFF_FFFF);
    wait_idle();
    // R4: wait hits the limit
    issue(4, 0, 1, POLL_MAX, 32'h0000_0000, 32'h0000_8001);
    wait_idle();
    // R4: one short of the limit, flag cleared
    ack_rand = 0;
    issue(1, 0, 1, POLL_MAX - 1, 32'hFFFF_FFFF, 32'h0000_0000);
    wait_idle();
    // R11: second command while busy is ignored
    ack_rand = 1;
    issue(2, 0, 1, 2, 32'h0000_4000, 32'h0000_0000);
    repeat (2) @(negedge clk);
    cmd_valid = 1; cmd_port = 3'd4; cmd_disable = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_disable = 0;
    wait_idle();
    // R8: disable commands
    issue(0, 1, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wait_idle();
    issue(4, 1, 1, 0, 32'h0000_4321, 32'h0000_8765);
    wait_idle();
    // R2: out-of-range ports
    issue(5, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    issue(7, 1, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    #1.5;
    chk(busy == 0 && acc_req == 0, "R2", "idle after dropped ports",
        {busy, acc_req}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule